// File: doc/BRIEF.md
# Lane Reset Sequencer

This block runs the reset sequence for one half of a sixteen-lane serial group. The caller gives a lane mask in natural order, where bit i stands for lane i. Only a mask that covers exactly the lower eight lanes or exactly the upper eight lanes is accepted. The control vectors are held in the opposite order, with lane 0 at the most significant bit, so the block turns the accepted mask into a register-order mask by taking its bitwise complement. It then works through the control vectors it models: a run-lane vector, receive and transmit I/O reset vectors, and one phase-rotator reset bit per lane.

After an accepted start, the sequencer clears the selected run-lane bits. It then waits as long as any selected lane reports busy. Next it pulses the I/O reset vectors in a fixed order: receive set, transmit set, receive clear, transmit clear. Last, it sets and then clears the phase-rotator reset bit of every selected lane. Each update is a read-modify-write that changes only the selected bits. A procedure controller drives the block through start, busy and done. States: IDLE, RUN_DROP, BUSY_WAIT, RX_SET, TX_SET, RX_CLR, TX_CLR, PR_SET, PR_CLR, FINISH. Transitions:
- IDLE to RUN_DROP on a start with a legal mask.
- RUN_DROP to BUSY_WAIT.
- BUSY_WAIT stays in BUSY_WAIT while a selected lane is busy, otherwise goes to RX_SET.
- RX_SET to TX_SET to RX_CLR to TX_CLR to PR_SET to PR_CLR to FINISH, one step per cycle.
- FINISH back to IDLE.

Top module: `lane_rst_seq`

## Requirements
- R1: After reset, the run-lane vector equals RUN_INIT, both I/O reset vectors equal IO_INIT, all phase-rotator bits are 0, and busy_o, done_o and err_o are 0.
- R2: A start in IDLE is accepted only if lane_mask_i is 16'h00FF or 16'hFF00. Any other mask sets err_o on the next cycle and leaves every vector and busy_o unchanged. err_o stays set until the next start in IDLE with a legal mask clears it.
- R3: The register-order mask is the complement of the lane mask, so lane i maps to bit 15-i. One cycle after the start is accepted, the selected run-lane bits are cleared and the other run-lane bits keep their values.
- R4: While lane_busy_i (register order) has any selected bit set, the sequence stays in its wait step and changes no vector. It leaves the wait step on the first clock where no selected bit is busy.
- R5: After the wait, four consecutive cycles apply these writes in this order, each touching only the selected bits: set them in the receive I/O reset vector, set them in the transmit vector, clear them in receive, clear them in transmit.
- R6: After the I/O pulse, pr_rst_o (lane order) goes high for the selected lanes for exactly one cycle and then returns low. Unselected lanes never change.
- R7: busy_o is high from the cycle after an accepted start through the last write. done_o is high for exactly the one cycle after the last write. busy_o and done_o are never high together.
- R8: A start seen while busy_o or done_o is high has no effect, whatever its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reset sequence (sampled in IDLE) |
| lane_mask_i | input | VEC_W | Lanes to reset, bit i = lane i |
| lane_busy_i | input | VEC_W | Lane busy flags, register order (lane 0 at MSB) |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start had an illegal mask |
| run_vec_o | output | VEC_W | Run-lane vector, register order |
| rx_iorst_o | output | VEC_W | Receive I/O reset vector, register order |
| tx_iorst_o | output | VEC_W | Transmit I/O reset vector, register order |
| pr_rst_o | output | VEC_W | Per-lane phase-rotator reset bits, lane order |

## Verification
The bench builds the block with RUN_INIT = 16'hF3C5 and IO_INIT = 16'h2481. With these values, unselected bits are set in both directions, so any read-modify-write that disturbs a bit outside the mask shows up at the ports. The sequence runs on both lane groups. Busy flags are raised both inside and outside the selected group, which reaches the wait stretch and the wait-free path. Illegal masks, error recovery and a start issued during a running sequence are also covered.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RUN_DROP,
        ST_BUSY_WAIT,
        ST_RX_SET,
        ST_TX_SET,
        ST_RX_CLR,
        ST_TX_CLR,
        ST_PR_SET,
        ST_PR_CLR,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RUN_CLR,
        OP_RX_SET,
        OP_TX_SET,
        OP_RX_CLR,
        OP_TX_CLR,
        OP_PR_SET,
        OP_PR_CLR
    } vec_op_t;

endpackage

// File: rtl/lrs_mask_dec.sv
module lrs_mask_dec #(
    parameter int VEC_W = 16
) (
    input  logic [VEC_W-1:0] lane_mask_i,
    output logic             legal_o,
    output logic [VEC_W-1:0] reg_mask_o
);
    localparam int GRP_W = VEC_W / 2;
    localparam logic [VEC_W-1:0] LOW_GRP  = {{(VEC_W-GRP_W){1'b0}}, {GRP_W{1'b1}}};
    localparam logic [VEC_W-1:0] HIGH_GRP = ~LOW_GRP;

    always_comb begin
        legal_o    = (lane_mask_i == LOW_GRP) || (lane_mask_i == HIGH_GRP);
        reg_mask_o = ~lane_mask_i;
    end
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
    import lrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       legal_i,
    input  logic       lanes_busy_i,
    output seq_state_t state_o,
    output vec_op_t    op_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    seq_state_t state_q, state_d;
    logic       err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                err_q <= !legal_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i && legal_i) state_d = ST_RUN_DROP;
            ST_RUN_DROP:  state_d = ST_BUSY_WAIT;
            ST_BUSY_WAIT: if (!lanes_busy_i) state_d = ST_RX_SET;
            ST_RX_SET:    state_d = ST_TX_SET;
            ST_TX_SET:    state_d = ST_RX_CLR;
            ST_RX_CLR:    state_d = ST_TX_CLR;
            ST_TX_CLR:    state_d = ST_PR_SET;
            ST_PR_SET:    state_d = ST_PR_CLR;
            ST_PR_CLR:    state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_o     = OP_NONE;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = start_i && legal_i;
            end
            ST_RUN_DROP:  op_o = OP_RUN_CLR;
            ST_BUSY_WAIT: op_o = OP_NONE;
            ST_RX_SET:    op_o = OP_RX_SET;
            ST_TX_SET:    op_o = OP_TX_SET;
            ST_RX_CLR:    op_o = OP_RX_CLR;
            ST_TX_CLR:    op_o = OP_TX_CLR;
            ST_PR_SET:    op_o = OP_PR_SET;
            ST_PR_CLR:    op_o = OP_PR_CLR;
            ST_FINISH: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default:      busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign err_o   = err_q;
endmodule

// File: rtl/lrs_vecfile.sv
module lrs_vecfile
    import lrs_pkg::*;
#(
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] RUN_INIT = '1,
    parameter logic [VEC_W-1:0] IO_INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vec_op_t          op_i,
    input  logic [VEC_W-1:0] reg_mask_i,
    input  logic [VEC_W-1:0] lane_mask_i,
    output logic [VEC_W-1:0] run_o,
    output logic [VEC_W-1:0] rx_o,
    output logic [VEC_W-1:0] tx_o,
    output logic [VEC_W-1:0] pr_o
);
    logic [VEC_W-1:0] run_q, rx_q, tx_q;

    function automatic logic [VEC_W-1:0] rmw(input logic [VEC_W-1:0] cur,
                                             input logic [VEC_W-1:0] sel,
                                             input logic             val);
        return (cur & ~sel) | ({VEC_W{val}} & sel);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_INIT;
            rx_q  <= IO_INIT;
            tx_q  <= IO_INIT;
        end else begin
            unique case (op_i)
                OP_RUN_CLR: run_q <= rmw(run_q, reg_mask_i, 1'b0);
                OP_RX_SET:  rx_q  <= rmw(rx_q,  reg_mask_i, 1'b1);
                OP_TX_SET:  tx_q  <= rmw(tx_q,  reg_mask_i, 1'b1);
                OP_RX_CLR:  rx_q  <= rmw(rx_q,  reg_mask_i, 1'b0);
                OP_TX_CLR:  tx_q  <= rmw(tx_q,  reg_mask_i, 1'b0);
                default: ;
            endcase
        end
    end

    for (genvar ln = 0; ln < VEC_W; ln++) begin : g_lane_pr
        logic pr_bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pr_bit_q <= 1'b0;
            end else if (lane_mask_i[ln]) begin
                if (op_i == OP_PR_SET)      pr_bit_q <= 1'b1;
                else if (op_i == OP_PR_CLR) pr_bit_q <= 1'b0;
            end
        end
        assign pr_o[ln] = pr_bit_q;
    end

    assign run_o = run_q;
    assign rx_o  = rx_q;
    assign tx_o  = tx_q;
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
    import lrs_pkg::*;
#(
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] RUN_INIT = '1,
    parameter logic [VEC_W-1:0] IO_INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [VEC_W-1:0] lane_mask_i,
    input  logic [VEC_W-1:0] lane_busy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [VEC_W-1:0] run_vec_o,
    output logic [VEC_W-1:0] rx_iorst_o,
    output logic [VEC_W-1:0] tx_iorst_o,
    output logic [VEC_W-1:0] pr_rst_o
);
    logic             mask_legal;
    logic [VEC_W-1:0] reg_mask_d;
    logic [VEC_W-1:0] reg_mask_q, lane_mask_q;
    logic             accept;
    seq_state_t       seq_state;
    vec_op_t          vec_op;

    lrs_mask_dec #(.VEC_W(VEC_W)) u_dec (
        .lane_mask_i (lane_mask_i),
        .legal_o     (mask_legal),
        .reg_mask_o  (reg_mask_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_mask_q  <= '0;
            lane_mask_q <= '0;
        end else if (accept) begin
            reg_mask_q  <= reg_mask_d;
            lane_mask_q <= lane_mask_i;
        end
    end

    lrs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .legal_i      (mask_legal),
        .lanes_busy_i (|(lane_busy_i & reg_mask_q)),
        .state_o      (seq_state),
        .op_o         (vec_op),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    lrs_vecfile #(
        .VEC_W    (VEC_W),
        .RUN_INIT (RUN_INIT),
        .IO_INIT  (IO_INIT)
    ) u_vec (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (vec_op),
        .reg_mask_i  (reg_mask_q),
        .lane_mask_i (lane_mask_q),
        .run_o       (run_vec_o),
        .rx_o        (rx_iorst_o),
        .tx_o        (tx_iorst_o),
        .pr_o        (pr_rst_o)
    );
endmodule

// File: rtl/lane_rst_seq_chk.sv
module lane_rst_seq_chk
    import lrs_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mask_legal,
    input logic [VEC_W-1:0] lane_busy_i,
    input logic [VEC_W-1:0] reg_mask_q,
    input seq_state_t       seq_state,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o,
    input logic [VEC_W-1:0] run_vec_o,
    input logic [VEC_W-1:0] rx_iorst_o,
    input logic [VEC_W-1:0] tx_iorst_o,
    input logic [VEC_W-1:0] pr_rst_o
);
    // R2: an illegal start raises the error and does not launch
    a_r2_illegal_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && start_i && !mask_legal) |=> (!busy_o && err_o));

    // R3: selected run bits are low once waiting
    a_r3_run_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_BUSY_WAIT) |-> ((run_vec_o & reg_mask_q) == '0));

    // R4: a selected busy lane holds the wait step and the I/O vectors
    a_r4_hold_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_BUSY_WAIT && |(lane_busy_i & reg_mask_q))
        |=> (seq_state == ST_BUSY_WAIT && $stable(rx_iorst_o) && $stable(tx_iorst_o)));

    // R5: transmit is set only after receive holds the selected bits
    a_r5_rx_before_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_TX_SET) |-> ((rx_iorst_o & reg_mask_q) == reg_mask_q));

    // R6: phase-rotator reset rises only after the I/O pulse has ended
    a_r6_pr_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|pr_rst_o) |-> (((rx_iorst_o | tx_iorst_o) & reg_mask_q) == '0));

    // R7: done lasts one cycle and never overlaps busy
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));
endmodule

bind lane_rst_seq lane_rst_seq_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mask_legal  (mask_legal),
    .lane_busy_i (lane_busy_i),
    .reg_mask_q  (reg_mask_q),
    .seq_state   (seq_state),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .run_vec_o   (run_vec_o),
    .rx_iorst_o  (rx_iorst_o),
    .tx_iorst_o  (tx_iorst_o),
    .pr_rst_o    (pr_rst_o)
);

// File: tb/lane_rst_seq_tb.sv
module lane_rst_seq_tb;
    localparam logic [15:0] P_RUN = 16'hF3C5;
    localparam logic [15:0] P_IO  = 16'h2481;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] lane_mask_i = '0;
    logic [15:0] lane_busy_i = '0;
    logic        busy_o, done_o, err_o;
    logic [15:0] run_vec_o, rx_iorst_o, tx_iorst_o, pr_rst_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    lane_rst_seq #(.VEC_W(16), .RUN_INIT(P_RUN), .IO_INIT(P_IO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .lane_mask_i(lane_mask_i), .lane_busy_i(lane_busy_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .run_vec_o(run_vec_o), .rx_iorst_o(rx_iorst_o),
        .tx_iorst_o(tx_iorst_o), .pr_rst_o(pr_rst_o)
    );

    // behavioural reference: a step counter and expected vectors
    int          m_step;
    logic [15:0] m_run, m_rx, m_tx, m_pr, m_sel_reg, m_sel_lane;
    logic        m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_step = 0; m_run = P_RUN; m_rx = P_IO; m_tx = P_IO;
            m_pr = '0; m_err = 1'b0; m_sel_reg = '0; m_sel_lane = '0;
        end else begin
            if (m_step == 0) begin
                if (start_i) begin
                    if (lane_mask_i == 16'h00FF || lane_mask_i == 16'hFF00) begin
                        m_sel_lane = lane_mask_i;
                        m_sel_reg  = ~lane_mask_i;
                        m_err = 1'b0;
                        m_step = 1;
                    end else begin
                        m_err = 1'b1;
                    end
                end
            end else if (m_step == 1) begin
                m_run = m_run & ~m_sel_reg; m_step = 2;
            end else if (m_step == 2) begin
                if ((lane_busy_i & m_sel_reg) == 0) m_step = 3;
            end else if (m_step == 3) begin m_rx = m_rx | m_sel_reg;   m_step = 4;
            end else if (m_step == 4) begin m_tx = m_tx | m_sel_reg;   m_step = 5;
            end else if (m_step == 5) begin m_rx = m_rx & ~m_sel_reg;  m_step = 6;
            end else if (m_step == 6) begin m_tx = m_tx & ~m_sel_reg;  m_step = 7;
            end else if (m_step == 7) begin m_pr = m_pr | m_sel_lane;  m_step = 8;
            end else if (m_step == 8) begin m_pr = m_pr & ~m_sel_lane; m_step = 9;
            end else begin
                m_step = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R3 run vector", run_vec_o, m_run);
            chk("R5 rx vector", rx_iorst_o, m_rx);
            chk("R5 tx vector", tx_iorst_o, m_tx);
            chk("R6 pr bits", pr_rst_o, m_pr);
            chk("R7 busy", {15'd0, busy_o}, {15'd0, (m_step >= 1 && m_step <= 8)});
            chk("R7 done", {15'd0, done_o}, {15'd0, (m_step == 9)});
            chk("R2 err", {15'd0, err_o}, {15'd0, m_err});
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 5000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp<=%0d", cyc, 5000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse_start(input logic [15:0] m);
        @(negedge clk);
        lane_mask_i = m;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 run init", run_vec_o, P_RUN);
        chk("R1 rx init", rx_iorst_o, P_IO);
        chk("R1 tx init", tx_iorst_o, P_IO);
        chk("R1 pr init", pr_rst_o, 16'h0000);
        chk("R1 flags", {13'd0, busy_o, done_o, err_o}, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: illegal mask is refused
        pulse_start(16'h0F0F);
        chk("R2 illegal err", {15'd0, err_o}, 16'h0001);
        chk("R2 illegal no busy", {15'd0, busy_o}, 16'h0000);
        chk("R2 illegal run kept", run_vec_o, P_RUN);

        // lower group with a selected busy lane (bit 15 = lane 0) plus unselected busy
        lane_busy_i = 16'h8001;
        pulse_start(16'h00FF);
        chk("R2 err cleared", {15'd0, err_o}, 16'h0000);
        repeat (5) @(negedge clk);
        // R4: still waiting, I/O vectors untouched
        chk("R4 wait busy", {15'd0, busy_o}, 16'h0001);
        chk("R4 wait rx kept", rx_iorst_o, P_IO);
        // R8: start during busy with the other group is ignored
        pulse_start(16'hFF00);
        lane_busy_i = 16'h0001;
        wait_done();
        // R3: lanes 0..7 live in bits 15..8
        chk("R3 lower run", run_vec_o, P_RUN & 16'h00FF);
        chk("R8 upper untouched", run_vec_o & 16'h00FF, P_RUN & 16'h00FF);

        // upper group, only unselected busy lanes: no wait
        lane_busy_i = 16'hFF00;
        pulse_start(16'hFF00);
        wait_done();
        chk("R3 upper run", run_vec_o, 16'h0000);
        chk("R5 rx final", rx_iorst_o, 16'h0000);

        // R2: all-ones mask refused, then recovery
        pulse_start(16'hFFFF);
        chk("R2 ffff err", {15'd0, err_o}, 16'h0001);
        lane_busy_i = '0;
        pulse_start(16'h00FF);
        wait_done();
        chk("R2 recovered", {15'd0, err_o}, 16'h0000);
        chk("R6 pr idle", pr_rst_o, 16'h0000);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule